// File: doc/BRIEF.md
# Shared Reserve-Line Tag Directory

This block keeps the tags for a pool of spare cache lines that every set of one cache bank may borrow. Each entry records one borrowed line: a valid flag, a dirty flag and the full line address (set index and tag together), because a pool entry is not tied to any one set. The pool holds SETS × RWAYS entries. The entry number is also the slot number in the spare data array, so no further mapping is required.

A lookup compares the request address against every entry in the same cycle. The comparators are grouped into banks of 16 entries, and all banks are evaluated side by side, so the lookup delay is that of one bank. An insert takes the lowest-numbered free entry. When no entry is free, it overwrites the least recently used entry across the whole pool and reports the displaced address and dirty flag so that a writeback can follow. An invalidate frees an entry once its line has been moved back into the regular ways of its set.

Requests on the three ports are taken one per cycle. Every response is registered and appears one clock after the request.

Top module: `rsv_tag_store`

## Requirements
- R1: After synchronous reset, every entry is free, and lk_done, lk_hit, ins_done and ev_valid read 0. A lookup issued after reset misses.
- R2: An accepted lookup whose address matches a valid entry raises lk_done and lk_hit on the next clock, with lk_idx set to that entry's number.
- R3: An accepted lookup that matches no valid entry raises lk_done with lk_hit = 0, lk_idx = 0 and lk_dirty = 0 on the next clock.
- R4: An insert while any entry is free is written into the lowest-numbered free entry. On the next clock, ins_done = 1, ins_idx = that entry and ev_valid = 0.
- R5: An insert while all entries are valid overwrites the least recently used entry in place. On the next clock, ins_done = 1, ins_idx = that entry, ev_valid = 1, and ev_tag and ev_dirty hold the address and dirty flag of the old occupant.
- R6: One recency order spans the whole pool. Each insert and each lookup hit makes the touched entry the most recently used. Just after reset, the order runs from entry 0 (least recent) to the last entry.
- R7: An invalidate of entry k makes k free. Later lookups of its address miss, and the next insert reuses the lowest free entry without eviction.
- R8: When requests coincide, insert beats invalidate and invalidate beats lookup. The losing request has no effect: no lk_done, and an invalidate that loses does not free its entry.
- R9: Entries in every 16-entry comparator bank are found, including entries numbered 16 and above. At most one bank reports a match in any cycle.
- R10: lk_dirty on a hit returns the dirty flag that was stored when the entry was inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | TAG_W | Line address to look up |
| ins_valid | input | 1 | Insert request |
| ins_tag | input | TAG_W | Line address to insert |
| ins_dirty | input | 1 | Dirty flag of the inserted line |
| inv_valid | input | 1 | Invalidate request |
| inv_idx | input | IW | Entry to invalidate |
| lk_done | output | 1 | Lookup response strobe |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_idx | output | IW | Matching entry / spare data slot |
| lk_dirty | output | 1 | Dirty flag of the matching entry |
| ins_done | output | 1 | Insert response strobe |
| ins_idx | output | IW | Entry that received the insert |
| ev_valid | output | 1 | An occupied entry was displaced |
| ev_tag | output | TAG_W | Address of the displaced line |
| ev_dirty | output | 1 | Displaced line needs writeback |

## Verification
The checker watches the handshake timing on every cycle. Each accepted lookup or insert must produce its strobe one clock later, a lookup that loses arbitration must produce no strobe, and a hit or an eviction report may appear only together with its strobe. The checker also requires that no two comparator banks match at once. Which entry is chosen, the global recency order across banks, reuse of freed entries and the reported victim address depend on history, so only the bench's directed sequences with precomputed expected indices and tags can show them.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int unsigned CMP_BANK = 16;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_INSERT = 2'd2,
    OP_INVAL  = 2'd3
  } rsv_op_e;
endpackage

// File: rtl/rsv_cmp_bank.sv
module rsv_cmp_bank #(
  parameter int TAG_W = 20,
  parameter int NENT  = 16,
  localparam int LW   = $clog2(NENT)
) (
  input  logic [NENT-1:0][TAG_W-1:0] tags,
  input  logic [NENT-1:0]            valid,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [LW-1:0]              hit_loc
);
  logic [NENT-1:0] match;

  always_comb begin
    for (int k = 0; k < NENT; k++) match[k] = valid[k] && (tags[k] == key);
  end

  always_comb begin
    hit     = 1'b0;
    hit_loc = '0;
    for (int k = 0; k < NENT; k++) begin
      if (match[k] && !hit) begin
        hit     = 1'b1;
        hit_loc = LW'(k);
      end
    end
  end
endmodule

// File: rtl/rsv_age_lru.sv
module rsv_age_lru #(
  parameter int NENT = 32,
  localparam int AW  = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [AW-1:0] touch_idx,
  output logic [AW-1:0] oldest_idx
);
  logic [AW-1:0] age_q [NENT];
  logic [AW-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  always_comb begin
    oldest_idx = '0;
    for (int k = 0; k < NENT; k++)
      if (age_q[k] == AW'(NENT - 1)) oldest_idx = AW'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NENT; k++) age_q[k] <= AW'(NENT - 1 - k);
    end else if (touch) begin
      for (int k = 0; k < NENT; k++) begin
        if (AW'(k) == touch_idx)         age_q[k] <= '0;
        else if (age_q[k] < touched_age) age_q[k] <= age_q[k] + AW'(1);
      end
    end
  end
endmodule

// File: rtl/rsv_tag_store.sv
module rsv_tag_store
  import rsv_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int RWAYS  = 4,
  parameter int TAG_W  = 20,
  localparam int ENTRIES = SETS * RWAYS,
  localparam int IW      = $clog2(ENTRIES),
  localparam int NSEG    = ENTRIES / CMP_BANK,
  localparam int LW      = $clog2(CMP_BANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             ins_valid,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             ins_dirty,
  input  logic             inv_valid,
  input  logic [IW-1:0]    inv_idx,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [IW-1:0]    lk_idx,
  output logic             lk_dirty,
  output logic             ins_done,
  output logic [IW-1:0]    ins_idx,
  output logic             ev_valid,
  output logic [TAG_W-1:0] ev_tag,
  output logic             ev_dirty
);
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, dirty_q;

  rsv_op_e op;
  always_comb begin
    if (ins_valid)      op = OP_INSERT;
    else if (inv_valid) op = OP_INVAL;
    else if (lk_valid)  op = OP_LOOKUP;
    else                op = OP_NONE;
  end

  // Parallel comparator banks
  logic [NSEG-1:0]         seg_hit;
  logic [NSEG-1:0][LW-1:0] seg_loc;

  for (genvar s = 0; s < NSEG; s++) begin : g_bank
    logic [CMP_BANK-1:0][TAG_W-1:0] bank_tags;
    always_comb begin
      for (int k = 0; k < CMP_BANK; k++) bank_tags[k] = tag_q[s*CMP_BANK + k];
    end
    rsv_cmp_bank #(.TAG_W(TAG_W), .NENT(CMP_BANK)) u_bank (
      .tags    (bank_tags),
      .valid   (valid_q[s*CMP_BANK +: CMP_BANK]),
      .key     (lk_tag),
      .hit     (seg_hit[s]),
      .hit_loc (seg_loc[s])
    );
  end

  logic          hit_any;
  logic [IW-1:0] hit_idx;
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (seg_hit[s] && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = IW'(s * CMP_BANK) + IW'(seg_loc[s]);
      end
    end
  end

  // Lowest free entry
  logic          any_free;
  logic [IW-1:0] free_idx;
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (!valid_q[k] && !any_free) begin
        any_free = 1'b1;
        free_idx = IW'(k);
      end
    end
  end

  logic [IW-1:0] victim_idx, slot;
  logic          touch;
  logic [IW-1:0] touch_idx;

  assign slot      = any_free ? free_idx : victim_idx;
  assign touch     = (op == OP_INSERT) || (op == OP_LOOKUP && hit_any);
  assign touch_idx = (op == OP_INSERT) ? slot : hit_idx;

  rsv_age_lru #(.NENT(ENTRIES)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch      (touch),
    .touch_idx  (touch_idx),
    .oldest_idx (victim_idx)
  );

  // Tag storage: write-only port, no reset
  always_ff @(posedge clk) begin
    if (op == OP_INSERT) tag_q[slot] <= ins_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      dirty_q  <= '0;
      lk_done  <= 1'b0;
      lk_hit   <= 1'b0;
      lk_idx   <= '0;
      lk_dirty <= 1'b0;
      ins_done <= 1'b0;
      ins_idx  <= '0;
      ev_valid <= 1'b0;
      ev_tag   <= '0;
      ev_dirty <= 1'b0;
    end else begin
      lk_done  <= (op == OP_LOOKUP);
      lk_hit   <= (op == OP_LOOKUP) && hit_any;
      lk_idx   <= ((op == OP_LOOKUP) && hit_any) ? hit_idx : '0;
      lk_dirty <= (op == OP_LOOKUP) && hit_any && dirty_q[hit_idx];
      ins_done <= (op == OP_INSERT);
      ins_idx  <= (op == OP_INSERT) ? slot : '0;
      ev_valid <= (op == OP_INSERT) && !any_free;
      ev_tag   <= ((op == OP_INSERT) && !any_free) ? tag_q[victim_idx] : '0;
      ev_dirty <= (op == OP_INSERT) && !any_free && dirty_q[victim_idx];
      if (op == OP_INSERT) begin
        valid_q[slot] <= 1'b1;
        dirty_q[slot] <= ins_dirty;
      end else if (op == OP_INVAL) begin
        valid_q[inv_idx] <= 1'b0;
        dirty_q[inv_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rsv_tag_store_chk.sv
module rsv_tag_store_chk #(
  parameter int NSEG = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic            ins_valid,
  input logic            inv_valid,
  input logic            lk_done,
  input logic            lk_hit,
  input logic            ins_done,
  input logic            ev_valid,
  input logic [NSEG-1:0] seg_hit
);
  AST_ONE_BANK_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_hit) <= 1); // R9
  AST_LOOKUP_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !ins_valid && !inv_valid) |=> lk_done); // R2
  AST_LOOKUP_YIELDS: assert property (@(posedge clk) disable iff (rst)
    (ins_valid || inv_valid) |=> !lk_done); // R8
  AST_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done); // R3
  AST_INSERT_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    ins_valid |=> ins_done); // R4
  AST_EVICT_WITH_INSERT: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> ins_done); // R5
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!lk_done && !ins_done && !ev_valid)); // R1
endmodule

bind rsv_tag_store rsv_tag_store_chk #(.NSEG(NSEG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .ins_valid (ins_valid),
  .inv_valid (inv_valid),
  .lk_done   (lk_done),
  .lk_hit    (lk_hit),
  .ins_done  (ins_done),
  .ev_valid  (ev_valid),
  .seg_hit   (seg_hit)
);

// File: tb/sim_rsv_tag_store.sv
module sim_rsv_tag_store;
  localparam int TAG_W = 20;
  localparam int IW    = 5;
  localparam int N     = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lk_valid = 1'b0, ins_valid = 1'b0, inv_valid = 1'b0;
  logic [TAG_W-1:0] lk_tag = '0, ins_tag = '0;
  logic             ins_dirty = 1'b0;
  logic [IW-1:0]    inv_idx = '0;
  logic             lk_done, lk_hit, lk_dirty, ins_done, ev_valid, ev_dirty;
  logic [IW-1:0]    lk_idx, ins_idx;
  logic [TAG_W-1:0] ev_tag;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rsv_tag_store #(.SETS(8), .RWAYS(4), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_tag(lk_tag),
    .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_dirty(ins_dirty),
    .inv_valid(inv_valid), .inv_idx(inv_idx),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_dirty(lk_dirty),
    .ins_done(ins_done), .ins_idx(ins_idx),
    .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_dirty(ev_dirty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of requests at a falling edge; return at the next falling edge.
  task automatic cyc(input bit l, input int lt, input bit i, input int it, input bit id,
                     input bit v, input int vx);
    lk_valid = l; lk_tag = TAG_W'(lt);
    ins_valid = i; ins_tag = TAG_W'(it); ins_dirty = id;
    inv_valid = v; inv_idx = IW'(vx);
    @(negedge clk);
    lk_valid = 0; ins_valid = 0; inv_valid = 0;
  endtask

  task automatic look(input int t, input bit eh, input int ei, input bit ed, input string req);
    cyc(1, t, 0, 0, 0, 0, 0);
    chk(lk_done == 1'b1, req, lk_done, 1);
    chk(lk_hit == eh, req, lk_hit, eh);
    chk(int'(lk_idx) == ei, req, lk_idx, ei);
    chk(lk_dirty == ed, req, lk_dirty, ed);
  endtask

  task automatic ins(input int t, input bit d, input int ei, input bit eev, input int et,
                     input bit ed, input string req);
    cyc(0, 0, 1, t, d, 0, 0);
    chk(ins_done == 1'b1, req, ins_done, 1);
    chk(int'(ins_idx) == ei, req, ins_idx, ei);
    chk(ev_valid == eev, req, ev_valid, eev);
    if (eev) begin
      chk(int'(ev_tag) == et, req, ev_tag, et);
      chk(ev_dirty == ed, req, ev_dirty, ed);
    end
  endtask

  task automatic t_reset();
    chk(lk_done == 0 && ins_done == 0 && ev_valid == 0, "R1 idle outputs",
        {lk_done, ins_done, ev_valid}, 0);
    look('h1005, 0, 0, 0, "R1/R3 miss after reset");
  endtask

  task automatic t_fill();
    for (int k = 0; k < N; k++) ins('h1000 + k, k[0], k, 0, 0, 0, "R4 free fill");
  endtask

  task automatic t_hits();
    look('h1003, 1, 3, 1, "R2/R10 hit bank0 dirty");
    look('h1014, 1, 20, 0, "R9/R10 hit bank1 clean");
    look('h1fff, 0, 0, 0, "R3 miss when full");
  endtask

  task automatic t_evict();
    ins('h2000, 1, 0, 1, 'h1000, 0, "R5 evict oldest");
    look('h1000, 0, 0, 0, "R5 old tag gone");
    look('h2000, 1, 0, 1, "R5 new tag in place");
    look('h1001, 1, 1, 1, "R6 touch entry 1");
    ins('h2001, 0, 2, 1, 'h1002, 0, "R6 global order skips touched");
    ins('h2002, 0, 4, 1, 'h1004, 0, "R6 hit on 3 kept it");
  endtask

  task automatic t_inval();
    cyc(0, 0, 0, 0, 0, 1, 7);
    cyc(0, 0, 0, 0, 0, 1, 5);
    look('h1007, 0, 0, 0, "R7 invalidated misses");
    ins('h2003, 1, 5, 0, 0, 0, "R7 lowest freed reused");
    ins('h2004, 0, 7, 0, 0, 0, "R7 next freed reused");
  endtask

  task automatic t_prio();
    cyc(1, 'h1008, 1, 'h3000, 0, 0, 0);
    chk(lk_done == 0, "R8 lookup loses to insert", lk_done, 0);
    chk(ins_done == 1 && int'(ins_idx) == 6, "R8 insert wins", ins_idx, 6);
    chk(ev_valid == 1 && int'(ev_tag) == 'h1006, "R8 insert evicts", ev_tag, 'h1006);
    cyc(1, 'h1008, 0, 0, 0, 1, 8);
    chk(lk_done == 0, "R8 lookup loses to invalidate", lk_done, 0);
    look('h1008, 0, 0, 0, "R8 invalidate applied");
    cyc(0, 0, 1, 'h3001, 1, 1, 9);
    chk(int'(ins_idx) == 8 && ev_valid == 0, "R8 insert beats invalidate", ins_idx, 8);
    look('h1009, 1, 9, 1, "R8 losing invalidate ignored");
    look('h3001, 1, 8, 1, "R10 dirty stored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_hits();
    t_evict();
    t_inval();
    t_prio();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule